// File: doc/BRIEF.md
# Totem-Pole Bridgeless Boost Gate Pattern Generator

This block turns a duty command into the four gate signals of a totem-pole bridgeless boost stage. A free-running counter builds a ramp in one of three shapes: rising, falling, or rising then falling. The ramp is compared against a compare value to form the boost duty. The two fast-leg outputs are driven as a complementary pair, and every rising edge is held back by a programmable number of clock cycles. The two slow-leg outputs stay static for the whole line half-cycle.

A line-polarity input decides which fast switch does the boosting and which slow switch conducts. New period and compare values are staged in shadow registers and take effect only at a period boundary. A polarity change also waits for a period boundary, and then passes through a changeover state in which all four outputs are low.

The controller has four states. ST_OFF is entered whenever the enable is low. ST_OFF goes to ST_POS or ST_NEG on the first enabled cycle, according to the polarity input. ST_POS moves to ST_SWAP at a period boundary when the polarity input reads negative. ST_NEG moves to ST_SWAP at a period boundary when the polarity input reads positive. ST_SWAP lasts dead-time plus one cycles and then enters the polarity that was latched when the changeover began.

Top module: `totem_pwm`

## Requirements
- R1: With `mode_sel`=0 the counter runs 0,1,…,P (P = `period_in`), so one period lasts P+1 cycles. The boost request is high while count < C (C = `cmp_in`), which gives C high cycles per period.
- R2: With `mode_sel`=1 the counter runs P,P−1,…,0, so one period lasts P+1 cycles. The boost request is high while count < C, which gives C high cycles per period.
- R3: With `mode_sel`=2 (P ≥ 1 required) the counter rises to P and falls back to 0, so one period lasts 2P cycles. The boost request is high while count < C, which gives 2C−1 high cycles per period for 1 ≤ C < P.
- R4: C = 0 keeps the boost output low and the synchronous output high without a break. C ≥ P keeps the boost output high and the synchronous output low without a break.
- R5: New P and C values are used only from a period boundary onward. The boundary is the cycle at count P in modes 0 and 2 (the peak in mode 2), and the cycle at count 0 in mode 1.
- R6: The fast outputs `fast_hi_o` and `fast_lo_o` are never high together. A fast output falls one cycle after its request drops, and it rises `dead_in` cycles later than it would without dead time. A request shorter than `dead_in`+1 cycles produces no pulse.
- R7: With `pol_pos`=1, `fast_lo_o` is the boost switch and `fast_hi_o` is the synchronous switch, `slow_lo_o` is held high and `slow_hi_o` is held low.
- R8: With `pol_pos`=0, `fast_hi_o` is the boost switch and `fast_lo_o` is the synchronous switch, `slow_hi_o` is held high and `slow_lo_o` is held low.
- R9: A polarity change is acted on only at a period boundary. After that boundary all four outputs are low for exactly `dead_in`+1 cycles, and then the slow output of the new polarity rises.
- R10: Reset holds all outputs low. One clock edge after `en` is sampled low, all four outputs are low. The counter restarts from its starting value (0, or P in mode 1) on re-enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Synchronous run enable; low forces outputs low |
| mode_sel | input | 2 | Ramp shape: 0 up, 1 down, 2 up-down (3 acts as up) |
| period_in | input | CNT_W | Period value P, staged until a boundary |
| cmp_in | input | CNT_W | Compare value C, staged until a boundary |
| dead_in | input | DT_W | Rising-edge delay in clock cycles |
| pol_pos | input | 1 | Line polarity, 1 = positive half-cycle |
| fast_hi_o | output | 1 | Upper fast switch gate |
| fast_lo_o | output | 1 | Lower fast switch gate |
| slow_hi_o | output | 1 | Upper slow switch gate |
| slow_lo_o | output | 1 | Lower slow switch gate |

## Verification
Every output is registered. A change of state or count therefore shows up one clock edge later, fast rising edges come a further `dead_in` cycles after that, and the outputs clear one edge after `en` falls. Inputs are driven and outputs are sampled on the falling clock edge. A cycle-level reference model advances on the rising edge and is compared on every cycle. Duty, dead-time and changeover checks count high or low cycles over windows that are whole multiples of the period, opened only after the shadow values have settled. This makes the counted results independent of the phase at which counting starts.

// File: rtl/totem_pwm_pkg.sv
package totem_pwm_pkg;

    typedef enum logic [1:0] {
        CM_UP   = 2'd0,
        CM_DOWN = 2'd1,
        CM_UPDN = 2'd2
    } cnt_mode_e;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_POS  = 2'd1,
        ST_NEG  = 2'd2,
        ST_SWAP = 2'd3
    } leg_state_e;

endpackage

// File: rtl/totem_pwm_ramp.sv
module totem_pwm_ramp
    import totem_pwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [1:0]       mode,
    input  logic [CNT_W-1:0] period_in,
    input  logic [CNT_W-1:0] cmp_in,
    output logic             raw,
    output logic             bnd,
    output logic [CNT_W-1:0] per_act,
    output logic [CNT_W-1:0] cmp_act
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    cnt_mode_e        m;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             dir_q, dir_d;
    logic             edge_c;

    assign m = cnt_mode_e'(mode);

    // next count and boundary detection
    always_comb begin
        cnt_d  = cnt_q;
        dir_d  = dir_q;
        edge_c = 1'b0;
        case (m)
            CM_DOWN: begin
                if (cnt_q == '0) begin
                    edge_c = 1'b1;
                    cnt_d  = period_in;
                end else begin
                    cnt_d = cnt_q - ONE;
                end
            end
            CM_UPDN: begin
                if (dir_q) begin
                    if (cnt_q >= per_act) begin
                        edge_c = 1'b1;
                        dir_d  = 1'b0;
                        cnt_d  = cnt_q - ONE;
                    end else begin
                        cnt_d = cnt_q + ONE;
                    end
                end else if (cnt_q == '0) begin
                    dir_d = 1'b1;
                    cnt_d = ONE;
                end else begin
                    cnt_d = cnt_q - ONE;
                end
            end
            default: begin
                if (cnt_q >= per_act) begin
                    edge_c = 1'b1;
                    cnt_d  = '0;
                end else begin
                    cnt_d = cnt_q + ONE;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            dir_q   <= 1'b1;
            per_act <= '0;
            cmp_act <= '0;
        end else if (!run) begin
            cnt_q   <= (m == CM_DOWN) ? period_in : '0;
            dir_q   <= 1'b1;
            per_act <= period_in;
            cmp_act <= cmp_in;
        end else begin
            cnt_q <= cnt_d;
            dir_q <= dir_d;
            if (edge_c) begin
                per_act <= period_in;
                cmp_act <= cmp_in;
            end
        end
    end

    assign bnd = edge_c & run;
    assign raw = (cmp_act >= per_act) | (cnt_q < cmp_act);

endmodule

// File: rtl/totem_pwm_dband.sv
module totem_pwm_dband #(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            req,
    input  logic [DT_W-1:0] dead,
    output logic            out
);

    logic [DT_W-1:0] dly_q;
    logic            out_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dly_q <= '0;
            out_q <= 1'b0;
        end else if (!run || !req) begin
            dly_q <= '0;
            out_q <= 1'b0;
        end else if (!out_q) begin
            if (dly_q >= dead) begin
                out_q <= 1'b1;
            end else begin
                dly_q <= dly_q + DT_W'(1);
            end
        end
    end

    assign out = out_q;

endmodule

// File: rtl/totem_pwm.sv
module totem_pwm
    import totem_pwm_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int DT_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [1:0]       mode_sel,
    input  logic [CNT_W-1:0] period_in,
    input  logic [CNT_W-1:0] cmp_in,
    input  logic [DT_W-1:0]  dead_in,
    input  logic             pol_pos,
    output logic             fast_hi_o,
    output logic             fast_lo_o,
    output logic             slow_hi_o,
    output logic             slow_lo_o
);

    localparam int N_FAST = 2;
    localparam int IDX_HI = 0;
    localparam int IDX_LO = 1;

    leg_state_e        state_q, state_d;
    logic [DT_W-1:0]   swap_cnt_q;
    logic              tgt_pos_q;
    logic              ramp_raw, ramp_bnd;
    logic [CNT_W-1:0]  per_act, cmp_act;
    logic [N_FAST-1:0] fast_req, fast_q;
    logic              slow_hi_d, slow_lo_d, slow_hi_q, slow_lo_q;

    totem_pwm_ramp #(.CNT_W(CNT_W)) u_ramp (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (en),
        .mode      (mode_sel),
        .period_in (period_in),
        .cmp_in    (cmp_in),
        .raw       (ramp_raw),
        .bnd       (ramp_bnd),
        .per_act   (per_act),
        .cmp_act   (cmp_act)
    );

    // next state
    always_comb begin
        state_d = state_q;
        if (!en) begin
            state_d = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF:  state_d = pol_pos ? ST_POS : ST_NEG;
                ST_POS:  if (ramp_bnd && !pol_pos) state_d = ST_SWAP;
                ST_NEG:  if (ramp_bnd && pol_pos)  state_d = ST_SWAP;
                ST_SWAP: if (swap_cnt_q >= dead_in)
                             state_d = tgt_pos_q ? ST_POS : ST_NEG;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_OFF;
            swap_cnt_q <= '0;
            tgt_pos_q  <= 1'b1;
        end else begin
            state_q    <= state_d;
            swap_cnt_q <= (state_q == ST_SWAP) ? swap_cnt_q + DT_W'(1) : '0;
            if (state_d == ST_SWAP && state_q != ST_SWAP) begin
                tgt_pos_q <= pol_pos;
            end
        end
    end

    // outputs per state
    always_comb begin
        fast_req  = '0;
        slow_hi_d = 1'b0;
        slow_lo_d = 1'b0;
        unique case (state_q)
            ST_POS: begin
                fast_req[IDX_LO] = ramp_raw;
                fast_req[IDX_HI] = ~ramp_raw;
                slow_lo_d        = 1'b1;
            end
            ST_NEG: begin
                fast_req[IDX_HI] = ramp_raw;
                fast_req[IDX_LO] = ~ramp_raw;
                slow_hi_d        = 1'b1;
            end
            ST_OFF, ST_SWAP: begin
                fast_req = '0;
            end
        endcase
    end

    for (genvar g = 0; g < N_FAST; g++) begin : g_leg
        totem_pwm_dband #(.DT_W(DT_W)) u_db (
            .clk   (clk),
            .rst_n (rst_n),
            .run   (en),
            .req   (fast_req[g]),
            .dead  (dead_in),
            .out   (fast_q[g])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slow_hi_q <= 1'b0;
            slow_lo_q <= 1'b0;
        end else begin
            slow_hi_q <= en & slow_hi_d;
            slow_lo_q <= en & slow_lo_d;
        end
    end

    assign fast_hi_o = fast_q[IDX_HI];
    assign fast_lo_o = fast_q[IDX_LO];
    assign slow_hi_o = slow_hi_q;
    assign slow_lo_o = slow_lo_q;

endmodule

// File: rtl/totem_pwm_chk.sv
module totem_pwm_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             fast_hi,
    input logic             fast_lo,
    input logic             slow_hi,
    input logic             slow_lo,
    input logic             bnd,
    input logic [CNT_W-1:0] per_act,
    input logic [CNT_W-1:0] cmp_act
);

    // R6
    fast_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fast_hi && fast_lo));

    // R7
    slow_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(slow_hi && slow_lo));

    // R10
    disable_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !(fast_hi || fast_lo || slow_hi || slow_lo));

    // R5
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !bnd) |=> ($stable(per_act) && $stable(cmp_act)));

    // R9
    slow_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(slow_lo) |-> !slow_hi);

endmodule

bind totem_pwm totem_pwm_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .fast_hi (fast_hi_o),
    .fast_lo (fast_lo_o),
    .slow_hi (slow_hi_o),
    .slow_lo (slow_lo_o),
    .bnd     (ramp_bnd),
    .per_act (per_act),
    .cmp_act (cmp_act)
);

// File: tb/totem_pwm_tb.sv
module totem_pwm_tb;

    localparam int  CW  = 16;
    localparam int  DW  = 8;
    localparam time TCK = 20ns;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0;
    logic          pol = 1'b1;
    logic [1:0]    mode = 2'd0;
    logic [CW-1:0] per = 16'd9;
    logic [CW-1:0] cmp = 16'd3;
    logic [DW-1:0] dead = 8'd0;
    logic          fhi, flo, shi, slo;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    bit    cmp_on = 1'b0;
    string tag = "R10";

    always #(TCK/2) clk = ~clk;

    totem_pwm #(.CNT_W(CW), .DT_W(DW)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .mode_sel  (mode),
        .period_in (per),
        .cmp_in    (cmp),
        .dead_in   (dead),
        .pol_pos   (pol),
        .fast_hi_o (fhi),
        .fast_lo_o (flo),
        .slow_hi_o (shi),
        .slow_lo_o (slo)
    );

    task automatic check(string rq, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    // reference model, built from the requirements
    logic [CW-1:0] m_cnt, m_per, m_cmp;
    logic          m_dir, m_tgt, m_shi, m_slo;
    int            m_st;
    logic [DW-1:0] m_sc;
    logic [DW-1:0] m_dc [2];
    logic          m_f  [2];

    task automatic db_step(int i, bit r);
        if (!en || !r) begin
            m_f[i] = 1'b0; m_dc[i] = '0;
        end else if (!m_f[i]) begin
            if (m_dc[i] >= dead) m_f[i] = 1'b1;
            else m_dc[i] = m_dc[i] + 1'b1;
        end
    endtask

    task automatic model_step();
        bit raw, rq_hi, rq_lo, sh, sl, bnd, nd;
        logic [CW-1:0] nc;
        int ns;
        raw = (m_cmp >= m_per) || (m_cnt < m_cmp);
        rq_hi = 0; rq_lo = 0; sh = 0; sl = 0;
        if (m_st == 1) begin rq_lo = raw; rq_hi = !raw; sl = 1; end
        if (m_st == 2) begin rq_hi = raw; rq_lo = !raw; sh = 1; end
        nc = m_cnt; nd = m_dir; bnd = 0;
        if (mode == 2'd1) begin
            if (m_cnt == 0) begin bnd = 1; nc = per; end else nc = m_cnt - 1'b1;
        end else if (mode == 2'd2) begin
            if (m_dir) begin
                if (m_cnt >= m_per) begin bnd = 1; nd = 0; nc = m_cnt - 1'b1; end
                else nc = m_cnt + 1'b1;
            end else if (m_cnt == 0) begin nd = 1; nc = 1; end
            else nc = m_cnt - 1'b1;
        end else begin
            if (m_cnt >= m_per) begin bnd = 1; nc = 0; end else nc = m_cnt + 1'b1;
        end
        db_step(0, rq_hi);
        db_step(1, rq_lo);
        m_shi = en & sh;
        m_slo = en & sl;
        ns = m_st;
        if (!en) ns = 0;
        else case (m_st)
            0: ns = pol ? 1 : 2;
            1: if (bnd && !pol) ns = 3;
            2: if (bnd && pol) ns = 3;
            default: if (m_sc >= dead) ns = m_tgt ? 1 : 2;
        endcase
        m_sc = (m_st == 3) ? m_sc + 1'b1 : '0;
        if (ns == 3 && m_st != 3) m_tgt = pol;
        m_st = ns;
        if (!en) begin
            m_cnt = (mode == 2'd1) ? per : '0; m_dir = 1; m_per = per; m_cmp = cmp;
        end else begin
            m_cnt = nc; m_dir = nd;
            if (bnd) begin m_per = per; m_cmp = cmp; end
        end
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = '0; m_per = '0; m_cmp = '0; m_dir = 1; m_tgt = 1;
            m_shi = 0; m_slo = 0; m_st = 0; m_sc = '0;
            m_dc[0] = '0; m_dc[1] = '0; m_f[0] = 0; m_f[1] = 0;
        end else begin
            model_step();
        end
    end

    always @(negedge clk) begin
        if (rst_n && cmp_on) begin
            check(tag, "fast_hi_o vs model", fhi, m_f[0]);
            check(tag, "fast_lo_o vs model", flo, m_f[1]);
            check(tag, "slow_hi_o vs model", shi, m_shi);
            check(tag, "slow_lo_o vs model", slo, m_slo);
        end
    end

    task automatic cfg(string t, int md, int p, int c, int d, int pp);
        @(negedge clk);
        en = 0; mode = 2'(md); per = CW'(p); cmp = CW'(c); dead = DW'(d); pol = pp[0]; tag = t;
        @(negedge clk);
        en = 1;
        repeat (40) @(negedge clk);
    endtask

    task automatic count(int n, output int c_hi, output int c_lo);
        c_hi = 0; c_lo = 0;
        repeat (n) begin
            if (fhi) c_hi++;
            if (flo) c_lo++;
            @(negedge clk);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        #(TCK * 100000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            summary();
            $finish;
        end
    end

    initial begin
        int a_hi, a_lo, w, z;
        void'($urandom(32'd51807));
        repeat (3) @(negedge clk);
        check("R10", "reset fast_hi_o", fhi, 0);
        check("R10", "reset fast_lo_o", flo, 0);
        check("R10", "reset slow_hi_o", shi, 0);
        check("R10", "reset slow_lo_o", slo, 0);
        rst_n = 1; cmp_on = 1;

        // R1 up count, positive polarity
        cfg("R1", 0, 9, 3, 0, 1);
        count(100, a_hi, a_lo);
        check("R1", "up boost high cycles", a_lo, 30);
        check("R6", "up sync high cycles", a_hi, 70);
        check("R7", "positive slow_lo_o", slo, 1);
        check("R7", "positive slow_hi_o", shi, 0);

        // R2 down count
        cfg("R2", 1, 9, 3, 0, 1);
        count(100, a_hi, a_lo);
        check("R2", "down boost high cycles", a_lo, 30);

        // R3 up-down count
        cfg("R3", 2, 8, 3, 0, 1);
        count(64, a_hi, a_lo);
        check("R3", "updown boost high cycles", a_lo, 20);
        check("R3", "updown sync high cycles", a_hi, 44);

        // R4 limits
        cfg("R4", 0, 9, 0, 0, 1);
        count(100, a_hi, a_lo);
        check("R4", "cmp 0 boost", a_lo, 0);
        check("R4", "cmp 0 sync", a_hi, 100);
        cfg("R4", 0, 9, 9, 0, 1);
        count(100, a_hi, a_lo);
        check("R4", "cmp=P boost", a_lo, 100);
        check("R4", "cmp=P sync", a_hi, 0);
        cfg("R4", 2, 8, 12, 0, 1);
        count(64, a_hi, a_lo);
        check("R4", "cmp>P updown boost", a_lo, 64);

        // R8 negative polarity
        cfg("R8", 0, 9, 3, 0, 0);
        count(100, a_hi, a_lo);
        check("R8", "negative boost on fast_hi_o", a_hi, 30);
        check("R8", "negative sync on fast_lo_o", a_lo, 70);
        check("R8", "negative slow_hi_o", shi, 1);
        check("R8", "negative slow_lo_o", slo, 0);

        // R6 dead time
        cfg("R6", 0, 9, 5, 3, 1);
        count(100, a_hi, a_lo);
        check("R6", "boost high with dead 3", a_lo, 20);
        check("R6", "sync high with dead 3", a_hi, 20);

        // R5 shadow load mid period
        cfg("R5", 0, 9, 3, 0, 1);
        repeat (4) @(negedge clk);
        cmp = 16'd7; per = 16'd19;
        repeat (60) @(negedge clk);
        count(200, a_hi, a_lo);
        check("R5", "new duty after boundary", a_lo, 70);

        // R9 polarity changeover
        cfg("R9", 0, 9, 3, 2, 1);
        pol = 0;
        w = 0;
        while (slo && w < 40) begin @(negedge clk); w++; end
        z = 0;
        while (!fhi && !flo && !shi && !slo && z < 20) begin z++; @(negedge clk); end
        check("R9", "all-low changeover cycles", z, 3);
        check("R9", "slow_hi_o after changeover", shi, 1);
        repeat (30) @(negedge clk);

        // R10 enable drop
        en = 0;
        @(negedge clk);
        check("R10", "disabled fast_hi_o", fhi, 0);
        check("R10", "disabled fast_lo_o", flo, 0);
        check("R10", "disabled slow_hi_o", shi, 0);
        check("R10", "disabled slow_lo_o", slo, 0);
        en = 1;
        repeat (40) @(negedge clk);

        // random stimulus against the model
        for (int i = 0; i < 40; i++) begin
            int md;
            string t;
            md = int'($urandom_range(0, 2));
            t = (md == 0) ? "R1" : ((md == 1) ? "R2" : "R3");
            cfg(t, md, int'($urandom_range(1, 20)), int'($urandom_range(0, 25)),
                int'($urandom_range(0, 4)), int'($urandom_range(0, 1)));
            for (int k = 0; k < 3; k++) begin
                cmp = CW'($urandom_range(0, 25));
                per = CW'($urandom_range(1, 20));
                pol = 1'($urandom_range(0, 1));
                repeat (int'($urandom_range(5, 50))) @(negedge clk);
            end
        end

        done = 1;
        cmp_on = 0;
        summary();
        $finish;
    end

endmodule